// File: doc/BRIEF.md
# Smartcard Character Transmitter with Error-Signal Retry Limit

This block sends bytes onto a half-duplex smartcard I/O line. It takes each byte from the head of an external transmit FIFO and frames it as a start bit, eight data bits and a parity bit, followed by guard time. Each bit lasts one elementary time unit (ETU), marked by a one-cycle `etu_tick` strobe from an external divider. The byte can be sent in one of two conventions. In the direct convention the line carries the data least significant bit first with true polarity. In the inverse convention it carries the data most significant bit first, with every data bit and the parity bit inverted. Parity is even or odd as selected.

The line is open-drain style. The block either pulls it low or releases it, and a released line idles high. The receive side reports a card error signal on `nack_in`. A report that arrives during a character's guard time marks that character as rejected. A rejected character is sent again from the FIFO head and is not popped. An accepted character is popped and the error count returns to zero. When the consecutive error count reaches a programmable limit, the block does three things together: it sets a sticky interrupt flag, pulses a FIFO flush and clears its own enable. A limit of zero turns the check off. Software starts transmission with a one-cycle enable pulse.

Top module: `sct_tx`

## Requirements
- R1: After reset the line is released (`line_low`=0), and `fifo_pop`, `fifo_flush`, `irq_flag` and `tx_enabled` are all 0.
- R2: A character starts on an ETU tick with a low start bit. Nine bit slots of one ETU each follow, then two guard ETUs with the line released. Line level high means logic 1.
- R3: When `inverse_conv`=0, data bit 0 is sent first and data bit 7 last, with no inversion of data or parity.
- R4: When `inverse_conv`=1, data bit 7 is sent first and data bit 0 last, and every data bit and the parity bit are sent inverted.
- R5: When `odd_parity`=0, the parity bit makes the count of ones over data and parity even. When `odd_parity`=1, it makes that count odd. The parity is computed before any inversion.
- R6: Start edges of consecutive characters are at least 12 ETUs apart. With the FIFO never empty and ticks every 4 cycles, they are exactly 13 ETUs apart.
- R7: An accepted character produces exactly one `fifo_pop` pulse after its guard time, and the error count resets to 0.
- R8: A `nack_in` pulse during the guard ETUs, including the cycle of the closing tick, causes the same byte to be resent with no pop.
- R9: When the consecutive error count reaches a nonzero `nack_limit`, the block sets `irq_flag`, pulses `fifo_flush` for one cycle and clears `tx_enabled`. No further character starts until `en_set` is pulsed again. `irq_clr` clears the flag.
- R10: With `nack_limit`=0, rejected characters are resent indefinitely, and neither the flag nor the disable ever occurs.
- R11: A `nack_in` pulse while data bits are on the line is ignored, and the character is accepted.
- R12: No character starts while `tx_enabled`=0 or the FIFO is empty. Only `en_set` sets `tx_enabled`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| etu_tick | input | 1 | One-cycle strobe per ETU |
| en_set | input | 1 | Pulse that sets the transmit enable |
| inverse_conv | input | 1 | 1 selects the inverse convention |
| odd_parity | input | 1 | 1 selects odd parity |
| nack_limit | input | 4 | Consecutive-error limit; 0 disables the limit |
| irq_clr | input | 1 | Clears the interrupt flag |
| fifo_empty | input | 1 | FIFO has no byte |
| fifo_data | input | 8 | Byte at the FIFO head |
| nack_in | input | 1 | Error signal reported by the receive side |
| fifo_pop | output | 1 | One-cycle pop of the FIFO head |
| fifo_flush | output | 1 | One-cycle FIFO flush |
| tx_enabled | output | 1 | Transmit enable state |
| irq_flag | output | 1 | Sticky retry-limit interrupt |
| line_low | output | 1 | 1 pulls the I/O line low; 0 releases it |

## Verification
The error window and the close of a character can fall in the same clock cycle. The bench raises `nack_in` exactly on the cycle of the final guard tick. It then checks that the byte is resent and counts toward the limit: with a limit of 2, that retry together with one more rejection must end in the flag, a single flush and the disable. The pop decision and the start of the next character can also meet. The bench judges this from the byte on the line, which must be the new FIFO head at exactly 13 ETUs, never the stale one.

// File: rtl/sct_pkg.sv
package sct_pkg;
  typedef enum logic {
    TX_IDLE = 1'b0,
    TX_SEND = 1'b1
  } tx_state_e;
endpackage

// File: rtl/sct_conv.sv
module sct_conv #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] byte_in,
  input  logic              inverse_conv,
  input  logic              odd_parity,
  output logic [DATA_W:0]   line_bits
);
  logic par_true;

  assign par_true = (^byte_in) ^ odd_parity;

  for (genvar gi = 0; gi < DATA_W; gi++) begin : g_order
    assign line_bits[gi] = inverse_conv ? ~byte_in[DATA_W-1-gi] : byte_in[gi];
  end

  assign line_bits[DATA_W] = inverse_conv ? ~par_true : par_true;
endmodule

// File: rtl/sct_serializer.sv
module sct_serializer
  import sct_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int GUARD_ETU = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            etu_tick,
  input  logic            go_ok,
  input  logic [DATA_W:0] frame_bits,
  input  logic            nack_in,
  output logic            line_low,
  output logic            busy,
  output logic            close_stb,
  output logic            close_nack
);
  localparam int LAST_ETU  = DATA_W + 1 + GUARD_ETU;
  localparam int CNT_W     = $clog2(LAST_ETU + 1);
  localparam int GUARD_ONE = DATA_W + 2;

  tx_state_e        state;
  logic [CNT_W-1:0] etu_cnt;
  logic [DATA_W:0]  shreg;
  logic             nack_seen;
  logic             in_guard;

  assign busy       = (state == TX_SEND);
  assign in_guard   = busy && (etu_cnt >= CNT_W'(GUARD_ONE));
  assign close_stb  = busy && etu_tick && (etu_cnt == CNT_W'(LAST_ETU));
  assign close_nack = nack_seen || nack_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= TX_IDLE;
      etu_cnt   <= '0;
      shreg     <= '0;
      line_low  <= 1'b0;
      nack_seen <= 1'b0;
    end else begin
      if (in_guard && nack_in) nack_seen <= 1'b1;
      case (state)
        TX_IDLE: begin
          if (etu_tick && go_ok) begin
            state     <= TX_SEND;
            etu_cnt   <= '0;
            shreg     <= frame_bits;
            line_low  <= 1'b1;
            nack_seen <= 1'b0;
          end
        end
        default: begin
          if (etu_tick) begin
            if (etu_cnt == CNT_W'(LAST_ETU)) begin
              state    <= TX_IDLE;
              line_low <= 1'b0;
            end else begin
              etu_cnt <= etu_cnt + 1'b1;
              if (etu_cnt <= CNT_W'(DATA_W)) begin
                line_low <= ~shreg[0];
                shreg    <= shreg >> 1;
              end else begin
                line_low <= 1'b0;
              end
            end
          end
        end
      endcase
    end
  end

  p_start_low_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> line_low);

  p_guard_released_r2: assert property (@(posedge clk) disable iff (rst)
    in_guard |-> !line_low);

  p_line_moves_on_tick_r2: assert property (@(posedge clk) disable iff (rst)
    !etu_tick |=> $stable(line_low));
endmodule

// File: rtl/sct_nack_ctr.sv
module sct_nack_ctr #(
  parameter int THR_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_set,
  input  logic             irq_clr,
  input  logic [THR_W-1:0] nack_limit,
  input  logic             close_stb,
  input  logic             close_nack,
  output logic             tx_enabled,
  output logic             irq_flag,
  output logic             fifo_pop,
  output logic             fifo_flush
);
  localparam logic [THR_W-1:0] CNT_MAX = '1;

  logic [THR_W-1:0] nack_cnt;
  logic [THR_W-1:0] cnt_next;
  logic             limit_hit;

  assign cnt_next  = (nack_cnt == CNT_MAX) ? nack_cnt : nack_cnt + 1'b1;
  assign limit_hit = (nack_limit != '0) && (cnt_next >= nack_limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_enabled <= 1'b0;
      irq_flag   <= 1'b0;
      fifo_pop   <= 1'b0;
      fifo_flush <= 1'b0;
      nack_cnt   <= '0;
    end else begin
      fifo_pop   <= 1'b0;
      fifo_flush <= 1'b0;
      if (irq_clr) irq_flag <= 1'b0;
      if (en_set) tx_enabled <= 1'b1;
      if (close_stb) begin
        if (!close_nack) begin
          fifo_pop <= 1'b1;
          nack_cnt <= '0;
        end else if (limit_hit) begin
          irq_flag   <= 1'b1;
          fifo_flush <= 1'b1;
          tx_enabled <= 1'b0;
          nack_cnt   <= '0;
        end else begin
          nack_cnt <= cnt_next;
        end
      end
    end
  end

  p_pop_flush_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(fifo_pop && fifo_flush));

  p_flush_disables_r9: assert property (@(posedge clk) disable iff (rst)
    fifo_flush |-> !tx_enabled);

  p_irq_with_flush_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_flag) |-> fifo_flush);

  p_zero_limit_no_flush_r10: assert property (@(posedge clk) disable iff (rst)
    (nack_limit == '0) && !close_stb |=> !fifo_flush);
endmodule

// File: rtl/sct_tx.sv
module sct_tx #(
  parameter int DATA_W    = 8,
  parameter int THR_W     = 4,
  parameter int GUARD_ETU = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              etu_tick,
  input  logic              en_set,
  input  logic              inverse_conv,
  input  logic              odd_parity,
  input  logic [THR_W-1:0]  nack_limit,
  input  logic              irq_clr,
  input  logic              fifo_empty,
  input  logic [DATA_W-1:0] fifo_data,
  input  logic              nack_in,
  output logic              fifo_pop,
  output logic              fifo_flush,
  output logic              tx_enabled,
  output logic              irq_flag,
  output logic              line_low
);
  logic [DATA_W:0] frame_bits;
  logic            go_ok;
  logic            busy;
  logic            close_stb;
  logic            close_nack;

  assign go_ok = tx_enabled && !fifo_empty && !fifo_pop && !fifo_flush;

  sct_conv #(.DATA_W(DATA_W)) u_conv (
    .byte_in      (fifo_data),
    .inverse_conv (inverse_conv),
    .odd_parity   (odd_parity),
    .line_bits    (frame_bits)
  );

  sct_serializer #(.DATA_W(DATA_W), .GUARD_ETU(GUARD_ETU)) u_ser (
    .clk        (clk),
    .rst        (rst),
    .etu_tick   (etu_tick),
    .go_ok      (go_ok),
    .frame_bits (frame_bits),
    .nack_in    (nack_in),
    .line_low   (line_low),
    .busy       (busy),
    .close_stb  (close_stb),
    .close_nack (close_nack)
  );

  sct_nack_ctr #(.THR_W(THR_W)) u_nack (
    .clk        (clk),
    .rst        (rst),
    .en_set     (en_set),
    .irq_clr    (irq_clr),
    .nack_limit (nack_limit),
    .close_stb  (close_stb),
    .close_nack (close_nack),
    .tx_enabled (tx_enabled),
    .irq_flag   (irq_flag),
    .fifo_pop   (fifo_pop),
    .fifo_flush (fifo_flush)
  );

  p_no_start_disabled_r12: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(tx_enabled) && !$past(fifo_empty));
endmodule

// File: tb/sct_tx_test.sv
module sct_tx_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       etu_tick = 1'b0;
  logic       en_set = 1'b0;
  logic       inverse_conv = 1'b0;
  logic       odd_parity = 1'b0;
  logic [3:0] nack_limit = 4'd0;
  logic       irq_clr = 1'b0;
  logic       fifo_empty = 1'b1;
  logic [7:0] fifo_data = 8'h00;
  logic       nack_in = 1'b0;
  logic       fifo_pop, fifo_flush, tx_enabled, irq_flag, line_low;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  int pops     = 0;
  int flushes  = 0;
  int frames   = 0;
  bit mon_busy = 0;
  bit done     = 0;

  logic [7:0] fifo_q[$];
  logic [8:0] exp_bits[$];
  int         exp_mode[$];
  int         exp_gap[$];

  sct_tx uut (
    .clk(clk), .rst(rst), .etu_tick(etu_tick), .en_set(en_set),
    .inverse_conv(inverse_conv), .odd_parity(odd_parity),
    .nack_limit(nack_limit), .irq_clr(irq_clr), .fifo_empty(fifo_empty),
    .fifo_data(fifo_data), .nack_in(nack_in), .fifo_pop(fifo_pop),
    .fifo_flush(fifo_flush), .tx_enabled(tx_enabled), .irq_flag(irq_flag),
    .line_low(line_low)
  );

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    etu_tick <= ((cyc % 4) == 3);
  end

  always @(posedge clk) begin
    if (!rst) begin
      if (fifo_pop) pops <= pops + 1;
      if (fifo_flush) flushes <= flushes + 1;
      if (fifo_flush) fifo_q.delete();
      else if (fifo_pop && fifo_q.size() > 0) void'(fifo_q.pop_front());
    end
    fifo_empty <= (fifo_q.size() == 0);
    fifo_data  <= (fifo_q.size() > 0) ? fifo_q[0] : 8'h00;
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [8:0] mk_frame(input logic [7:0] b, input bit inv, input bit odd);
    int ones = 0;
    logic p;
    logic [8:0] r;
    for (int k = 0; k < 8; k++) ones += b[k];
    p = ((ones % 2) == 1) ^ odd;
    for (int k = 0; k < 8; k++) r[k] = inv ? ~b[7-k] : b[k];
    r[8] = inv ? ~p : p;
    return r;
  endfunction

  task automatic expect_frame(input logic [7:0] b, input int mode, input int gap);
    exp_bits.push_back(mk_frame(b, inverse_conv, odd_parity));
    exp_mode.push_back(mode);
    exp_gap.push_back(gap);
  endtask

  task automatic wait_idle();
    while (exp_bits.size() != 0 || mon_busy) @(negedge clk);
    repeat (70) @(negedge clk);
  endtask

  // Monitor: pops expected frames and compares the line
  initial begin
    logic prev_low = 1'b0;
    int last_start = -1000;
    forever begin
      @(negedge clk);
      if (!rst && line_low && !prev_low) begin
        logic [8:0] got;
        logic [8:0] want;
        int mode, gap, here;
        mon_busy = 1;
        frames++;
        here = cyc;
        if (exp_bits.size() == 0) begin
          chk(0, "R12 unexpected character", 1, 0);
          want = 9'h0; mode = 0; gap = 0;
        end else begin
          want = exp_bits.pop_front();
          mode = exp_mode.pop_front();
          gap  = exp_gap.pop_front();
        end
        chk(here - last_start >= 48, "R6 spacing", here - last_start, 48);
        if (gap != 0) chk(here - last_start == gap, "R6 back-to-back gap", here - last_start, gap);
        last_start = here;
        for (int i = 0; i < 9; i++) begin
          if (mode == 3 && i == 5) begin
            @(negedge clk); nack_in = 1'b1;
            @(negedge clk); nack_in = 1'b0;
            repeat (2) @(negedge clk);
          end else begin
            repeat (4) @(negedge clk);
          end
          got[i] = ~line_low;
        end
        chk(got == want, "R3/R4/R5 character bits", got, want);
        repeat (4) @(negedge clk);
        chk(!line_low, "R2 guard one released", line_low, 0);
        if (mode == 1) begin
          @(negedge clk); nack_in = 1'b1;
          @(negedge clk); nack_in = 1'b0;
          repeat (2) @(negedge clk);
        end else begin
          repeat (4) @(negedge clk);
        end
        chk(!line_low, "R2 guard two released", line_low, 0);
        if (mode == 2) begin
          repeat (3) @(negedge clk); nack_in = 1'b1;
          @(negedge clk); nack_in = 1'b0;
        end
        mon_busy = 0;
      end
      prev_low = line_low;
    end
  end

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_up();
  end

  initial begin
    int p0, f0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(line_low == 0, "R1 line", line_low, 0);
    chk(fifo_pop == 0 && fifo_flush == 0, "R1 pop/flush", {fifo_pop, fifo_flush}, 0);
    chk(irq_flag == 0, "R1 irq", irq_flag, 0);
    chk(tx_enabled == 0, "R1 enable", tx_enabled, 0);

    // R12: data waiting but not enabled
    fifo_q.push_back(8'hA5); fifo_q.push_back(8'h3C); fifo_q.push_back(8'h01);
    repeat (120) @(negedge clk);
    chk(frames == 0, "R12 no start while disabled", frames, 0);
    chk(fifo_q.size() == 3, "R12 no pop while disabled", fifo_q.size(), 3);

    // R2/R3/R5/R6/R7: direct, even parity, back-to-back
    nack_limit = 4'd3;
    p0 = pops;
    expect_frame(8'hA5, 0, 0);
    expect_frame(8'h3C, 0, 52);
    expect_frame(8'h01, 0, 52);
    en_set = 1'b1; @(negedge clk); en_set = 1'b0;
    chk(tx_enabled == 1, "R12 enable set", tx_enabled, 1);
    wait_idle();
    chk(pops - p0 == 3, "R7 one pop per character", pops - p0, 3);

    // R5: odd parity, direct
    odd_parity = 1'b1;
    expect_frame(8'h00, 0, 0); expect_frame(8'hFF, 0, 52);
    fifo_q.push_back(8'h00); fifo_q.push_back(8'hFF);
    wait_idle();

    // R4: inverse convention with both parities
    inverse_conv = 1'b1; odd_parity = 1'b0;
    expect_frame(8'h3B, 0, 0); expect_frame(8'h80, 0, 52);
    fifo_q.push_back(8'h3B); fifo_q.push_back(8'h80);
    wait_idle();
    odd_parity = 1'b1;
    expect_frame(8'h6E, 0, 0);
    fifo_q.push_back(8'h6E);
    wait_idle();
    inverse_conv = 1'b0; odd_parity = 1'b0;

    // R8 + R7 count reset: limit 3, two rejections per byte, four total
    p0 = pops;
    expect_frame(8'h12, 1, 0); expect_frame(8'h12, 1, 52); expect_frame(8'h12, 0, 52);
    expect_frame(8'h34, 1, 52); expect_frame(8'h34, 1, 52); expect_frame(8'h34, 0, 52);
    fifo_q.push_back(8'h12); fifo_q.push_back(8'h34);
    wait_idle();
    chk(pops - p0 == 2, "R8 no pop on retry", pops - p0, 2);
    chk(irq_flag == 0, "R7 count reset on accept", irq_flag, 0);
    chk(tx_enabled == 1, "R7 still enabled", tx_enabled, 1);

    // R11: error during data ignored, limit 1
    nack_limit = 4'd1;
    expect_frame(8'h5A, 3, 0); expect_frame(8'hC3, 0, 52);
    fifo_q.push_back(8'h5A); fifo_q.push_back(8'hC3);
    wait_idle();
    chk(irq_flag == 0, "R11 data-time error ignored", irq_flag, 0);

    // R9 + R8 coincident close: limit 2
    nack_limit = 4'd2;
    p0 = pops; f0 = flushes;
    expect_frame(8'h66, 2, 0); expect_frame(8'h66, 1, 52);
    fifo_q.push_back(8'h66); fifo_q.push_back(8'h77);
    wait_idle();
    chk(irq_flag == 1, "R9 irq set", irq_flag, 1);
    chk(tx_enabled == 0, "R9 disabled", tx_enabled, 0);
    chk(flushes - f0 == 1, "R9 single flush", flushes - f0, 1);
    chk(pops - p0 == 0, "R9 no pop", pops - p0, 0);
    chk(fifo_q.size() == 0, "R9 fifo flushed", fifo_q.size(), 0);
    fifo_q.push_back(8'h77);
    repeat (120) @(negedge clk);
    chk(fifo_q.size() == 1, "R9 no start after disable", fifo_q.size(), 1);
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
    chk(irq_flag == 0, "R9 irq cleared", irq_flag, 0);

    // R10: limit 0, four rejections then accept
    nack_limit = 4'd0;
    p0 = pops; f0 = flushes;
    expect_frame(8'h77, 1, 0);
    for (int k = 0; k < 3; k++) expect_frame(8'h77, 1, 52);
    expect_frame(8'h77, 0, 52);
    en_set = 1'b1; @(negedge clk); en_set = 1'b0;
    wait_idle();
    chk(irq_flag == 0 && tx_enabled == 1, "R10 no limit", {irq_flag, tx_enabled}, 1);
    chk(flushes - f0 == 0 && pops - p0 == 1, "R10 accepted once", pops - p0, 1);

    finish_up();
  end
endmodule